// File: doc/BRIEF.md
# Sleep and Power-Reduction Controller

This block is the power-management control point of a small microcontroller-style subsystem. Software reaches two byte-wide registers over a simple synchronous bus. The mode-control register holds a sleep-enable flag and a two-bit sleep-mode select. Its other bits are plain storage for neighbouring logic. The gating register holds one stop bit per peripheral: timer 1, timer 0, a serial interface unit and a USART.

The core sends a one-cycle sleep pulse when it executes its sleep instruction. The controller enters the selected sleep mode only if sleep-enable is already set at that moment. It stays asleep until a wake event arrives. While asleep it reports the active mode on one-hot flags. It drives a per-peripheral clock-enable vector at all times. In the light mode the enables follow the stop bits. In the two deep modes every enable is forced low.

The controller never clears sleep-enable by itself; software clears it after waking. The clock tree, the oscillators and the interrupt logic that produces the wake event are outside this block.

Top module: `pwr_sleep_ctrl`

## Requirements
- R1: After reset both registers read zero, the block is awake, all mode flags are low and all four clock enables are high.
- R2: The mode-control register (address 0) stores and reads back all 8 bits. Bit 6 is the high select bit, bit 4 is the low select bit and bit 5 is sleep-enable.
- R3: The gating register (address 1) stores bits 3..0: bit 3 is timer 1, bit 2 is timer 0, bit 1 is the serial interface unit and bit 0 is the USART. Bits 7..4 ignore writes and always read zero.
- R4: Any other address reads zero, and a write to it leaves both registers unchanged.
- R5: A sleep pulse with sleep-enable set makes the block asleep on the next cycle. The select {bit6,bit4} decodes as 00 idle, 01 power-down, 10 standby and 11 power-down, and exactly one flag (slp_idle_o, slp_pdown_o or slp_stby_o) is high while asleep.
- R6: A sleep pulse with sleep-enable clear has no effect: the block stays awake.
- R7: A wake event while asleep makes the block awake on the next cycle, and the sleep-enable bit keeps its value.
- R8: While awake or in idle, each clock enable is the inverse of its gating bit.
- R9: In power-down and in standby, all four clock enables are low, whatever the gating bits hold.
- R10: Clearing a gating bit raises that peripheral's clock enable on the cycle after the write, when no deep mode is active.
- R11: The mode is captured at sleep entry. Writing the select bits while asleep does not change the mode flags until wake.
- R12: A wake event in the same cycle as a sleep pulse stops sleep entry. A sleep pulse while already asleep is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, one cycle after the address |
| sleep_req | input | 1 | One-cycle sleep-instruction pulse |
| wake_evt | input | 1 | Wake event |
| asleep_o | output | 1 | High while in any sleep mode |
| slp_idle_o | output | 1 | Idle mode active |
| slp_pdown_o | output | 1 | Power-down mode active |
| slp_stby_o | output | 1 | Standby mode active |
| periph_clk_en_o | output | 4 | Clock enables: bit 3 timer 1, bit 2 timer 0, bit 1 serial unit, bit 0 USART |

## Verification
All four select codes are tried. Each entry is taken with a different gating pattern, so the light mode shows its pattern passed through to the clock enables, while the deep modes show the pattern suppressed. Codes 01 and 11 must give the same flag, which shows the aliasing, and code 10 must not. Sleep pulses are also sent with sleep-enable clear, together with a wake event, and while already asleep, which separates a real entry from the cases that must be ignored. Select writes made during sleep show that the mode is held at the value captured at entry.

// File: rtl/pwr_sleep_pkg.sv
package pwr_sleep_pkg;

    localparam int unsigned REG_W      = 8;
    localparam int unsigned SEL_HI_BIT = 6;
    localparam int unsigned SE_BIT     = 5;
    localparam int unsigned SEL_LO_BIT = 4;

    typedef enum logic [1:0] {
        ST_AWAKE = 2'd0,
        ST_IDLE  = 2'd1,
        ST_PDOWN = 2'd2,
        ST_STBY  = 2'd3
    } slp_state_e;

    // Select code {hi,lo}: 00 light, 10 standby, 01 and 11 both deepest.
    function automatic slp_state_e sel_to_state(input logic [1:0] sel);
        slp_state_e r;
        case (sel)
            2'b00:   r = ST_IDLE;
            2'b10:   r = ST_STBY;
            default: r = ST_PDOWN;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pwr_sleep_regs.sv
module pwr_sleep_regs
    import pwr_sleep_pkg::*;
#(
    parameter int unsigned ADDR_W     = 2,
    parameter int unsigned NUM_PERIPH = 4,
    parameter int unsigned MODE_ADDR  = 0,
    parameter int unsigned GATE_ADDR  = 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_wr,
    input  logic [REG_W-1:0]      bus_wdata,
    output logic [REG_W-1:0]      bus_rdata,
    output logic [REG_W-1:0]      mode_reg_o,
    output logic [NUM_PERIPH-1:0] gate_bits_o
);

    localparam logic [ADDR_W-1:0] MODE_A = ADDR_W'(MODE_ADDR);
    localparam logic [ADDR_W-1:0] GATE_A = ADDR_W'(GATE_ADDR);

    typedef struct packed {
        logic [REG_W-1:0]      mode;
        logic [NUM_PERIPH-1:0] gate;
        logic [REG_W-1:0]      rdata;
    } regs_t;

    regs_t q, d;
    logic [REG_W-1:0] gate_view;

    // Gating register as seen on the bus: unused upper bits are tied low.
    generate
        if (NUM_PERIPH < REG_W) begin : g_pad
            assign gate_view = {{(REG_W-NUM_PERIPH){1'b0}}, q.gate};

            AST_RESV_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_addr == GATE_A) |=> (bus_rdata[REG_W-1:NUM_PERIPH] == '0)); // R3
        end else begin : g_full
            assign gate_view = q.gate[REG_W-1:0];
        end
    endgenerate

    always_comb begin
        d = q;
        if (bus_wr) begin
            if (bus_addr == MODE_A) d.mode = bus_wdata;
            if (bus_addr == GATE_A) d.gate = bus_wdata[NUM_PERIPH-1:0];
        end
        if (bus_addr == MODE_A)      d.rdata = q.mode;
        else if (bus_addr == GATE_A) d.rdata = gate_view;
        else                         d.rdata = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign bus_rdata   = q.rdata;
    assign mode_reg_o  = q.mode;
    assign gate_bits_o = q.gate;

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != MODE_A && bus_addr != GATE_A) |=> (bus_rdata == '0)); // R4

    AST_REGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> ($stable(mode_reg_o) && $stable(gate_bits_o))); // R2

endmodule

// File: rtl/pwr_sleep_fsm.sv
module pwr_sleep_fsm
    import pwr_sleep_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_req,
    input  logic       wake_evt,
    input  logic       se,
    input  logic [1:0] sel,
    output slp_state_e state_o
);

    typedef struct packed {
        slp_state_e st;
    } fsm_t;

    fsm_t q, d;

    always_comb begin
        d = q;
        if (q.st == ST_AWAKE) begin
            if (sleep_req && se && !wake_evt) d.st = sel_to_state(sel);
        end else if (wake_evt) begin
            d.st = ST_AWAKE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_AWAKE};
        else        q <= d;
    end

    assign state_o = q.st;

    AST_NO_ENABLE_NO_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_AWAKE && !se) |=> (state_o == ST_AWAKE)); // R6

    AST_ALIAS_DEEPEST: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_AWAKE && sleep_req && se && !wake_evt && sel[0])
        |=> (state_o == ST_PDOWN)); // R5

    AST_WAKE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o != ST_AWAKE && wake_evt) |=> (state_o == ST_AWAKE)); // R7

    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o != ST_AWAKE && !wake_evt) |=> $stable(state_o)); // R11

    AST_WAKE_BLOCKS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_AWAKE && wake_evt) |=> (state_o == ST_AWAKE)); // R12

endmodule

// File: rtl/pwr_sleep_gate.sv
module pwr_sleep_gate
    import pwr_sleep_pkg::*;
#(
    parameter int unsigned NUM_PERIPH = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  slp_state_e            state,
    input  logic [NUM_PERIPH-1:0] gate_bits,
    output logic [NUM_PERIPH-1:0] clk_en
);

    logic deep;
    assign deep = (state == ST_PDOWN) || (state == ST_STBY);

    generate
        for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_lane
            assign clk_en[i] = !gate_bits[i] && !deep;

            AST_RESTORE_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
                (!deep && $fell(gate_bits[i])) |-> clk_en[i]); // R10
        end
    endgenerate

    AST_DEEP_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STBY || state == ST_PDOWN) |-> (clk_en == '0)); // R9

endmodule

// File: rtl/pwr_sleep_ctrl.sv
module pwr_sleep_ctrl
    import pwr_sleep_pkg::*;
#(
    parameter int unsigned ADDR_W     = 2,
    parameter int unsigned NUM_PERIPH = 4,
    parameter int unsigned MODE_ADDR  = 0,
    parameter int unsigned GATE_ADDR  = 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_wr,
    input  logic [7:0]            bus_wdata,
    output logic [7:0]            bus_rdata,
    input  logic                  sleep_req,
    input  logic                  wake_evt,
    output logic                  asleep_o,
    output logic                  slp_idle_o,
    output logic                  slp_pdown_o,
    output logic                  slp_stby_o,
    output logic [NUM_PERIPH-1:0] periph_clk_en_o
);

    logic [REG_W-1:0]      mode_reg;
    logic [NUM_PERIPH-1:0] gate_bits;
    slp_state_e            state;

    pwr_sleep_regs #(
        .ADDR_W    (ADDR_W),
        .NUM_PERIPH(NUM_PERIPH),
        .MODE_ADDR (MODE_ADDR),
        .GATE_ADDR (GATE_ADDR)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .mode_reg_o (mode_reg),
        .gate_bits_o(gate_bits)
    );

    pwr_sleep_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sleep_req(sleep_req),
        .wake_evt (wake_evt),
        .se       (mode_reg[SE_BIT]),
        .sel      ({mode_reg[SEL_HI_BIT], mode_reg[SEL_LO_BIT]}),
        .state_o  (state)
    );

    pwr_sleep_gate #(
        .NUM_PERIPH(NUM_PERIPH)
    ) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .state    (state),
        .gate_bits(gate_bits),
        .clk_en   (periph_clk_en_o)
    );

    assign asleep_o    = (state != ST_AWAKE);
    assign slp_idle_o  = (state == ST_IDLE);
    assign slp_pdown_o = (state == ST_PDOWN);
    assign slp_stby_o  = (state == ST_STBY);

    AST_ENABLE_KEPT_ON_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep_o && wake_evt && !bus_wr) |=> $stable(mode_reg[SE_BIT])); // R7

endmodule

// File: tb/pwr_sleep_ctrl_test.sv
`timescale 1ns/1ps
module pwr_sleep_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       sleep_req = 1'b0;
    logic       wake_evt = 1'b0;
    logic       asleep_o, slp_idle_o, slp_pdown_o, slp_stby_o;
    logic [3:0] periph_clk_en_o;

    always #2 clk = ~clk;

    pwr_sleep_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sleep_req(sleep_req),
        .wake_evt(wake_evt), .asleep_o(asleep_o), .slp_idle_o(slp_idle_o),
        .slp_pdown_o(slp_pdown_o), .slp_stby_o(slp_stby_o),
        .periph_clk_en_o(periph_clk_en_o)
    );

    typedef struct {
        string      req;
        bit         chk_rd;
        logic [7:0] rd;
        logic       slp;
        logic [2:0] md;   // {stby, pdown, idle}
        logic [3:0] ce;
    } exp_t;

    exp_t q_exp[$];
    event chk_ev;
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    // Bench model: 0 awake, 1 idle, 2 power-down, 3 standby
    logic [7:0] m_mode = '0;
    logic [3:0] m_gate = '0;
    int         m_state = 0;

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic push(input string req, input bit chk_rd, input logic [7:0] rd);
        exp_t e;
        e.req    = req;
        e.chk_rd = chk_rd;
        e.rd     = rd;
        e.slp    = (m_state != 0);
        e.md     = (m_state == 1) ? 3'b001 : (m_state == 2) ? 3'b010 :
                   (m_state == 3) ? 3'b100 : 3'b000;
        e.ce     = (m_state >= 2) ? 4'b0000 : ~m_gate;
        q_exp.push_back(e);
        -> chk_ev;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] dta);
        bus_addr = a; bus_wdata = dta; bus_wr = 1'b1;
        tick();
        bus_wr = 1'b0;
        if (a == 2'd0) m_mode = dta;
        if (a == 2'd1) m_gate = dta[3:0];
    endtask

    task automatic rd(input logic [1:0] a, input string req);
        logic [7:0] ex;
        bus_addr = a;
        tick();
        ex = (a == 2'd0) ? m_mode : (a == 2'd1) ? {4'b0000, m_gate} : 8'h00;
        push(req, 1'b1, ex);
    endtask

    task automatic slp(input bit with_wake, input string req);
        sleep_req = 1'b1; wake_evt = with_wake;
        tick();
        sleep_req = 1'b0; wake_evt = 1'b0;
        if (m_state == 0 && m_mode[5] && !with_wake) begin
            case ({m_mode[6], m_mode[4]})
                2'b00:   m_state = 1;
                2'b10:   m_state = 3;
                default: m_state = 2;
            endcase
        end else if (with_wake) begin
            m_state = 0;
        end
        push(req, 1'b0, 8'h00);
    endtask

    task automatic wk(input string req);
        wake_evt = 1'b1;
        tick();
        wake_evt = 1'b0;
        m_state = 0;
        push(req, 1'b0, 8'h00);
    endtask

    task automatic status(input string req);
        push(req, 1'b0, 8'h00);
    endtask

    // Monitor: pops expectations and compares against the ports
    initial begin
        forever begin
            @(chk_ev);
            while (q_exp.size() > 0) begin
                exp_t e;
                logic [15:0] act, exv;
                e   = q_exp.pop_front();
                act = {(e.chk_rd ? bus_rdata : 8'h00), asleep_o,
                       slp_stby_o, slp_pdown_o, slp_idle_o, periph_clk_en_o};
                exv = {(e.chk_rd ? e.rd : 8'h00), e.slp, e.md, e.ce};
                n_cmp++;
                if (act !== exv) begin
                    n_bad++;
                    $display("FAIL %s: actual=%h expected=%h (rdata,asleep,stby,pdown,idle,clk_en)",
                             e.req, act, exv);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R1 watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1: reset state
        status("R1 reset outputs");
        rd(2'd0, "R1 mode reg after reset");
        rd(2'd1, "R1 gating reg after reset");

        // R2: full read/write of mode register
        wr(2'd0, 8'h9A);
        rd(2'd0, "R2 mode reg readback 9A");
        wr(2'd0, 8'h45);
        rd(2'd0, "R2 mode reg readback 45");

        // R3: reserved gating bits
        wr(2'd1, 8'hFF);
        rd(2'd1, "R3 gating write FF reads 0F");
        status("R3 R8 all clocks off when awake");
        wr(2'd1, 8'hF0);
        rd(2'd1, "R3 reserved-only write reads 00");
        status("R3 reserved write leaves clocks on");

        // R4: unmapped address
        wr(2'd1, 8'h06);
        wr(2'd3, 8'hFF);
        rd(2'd3, "R4 unmapped reads zero");
        rd(2'd0, "R4 mode reg untouched");
        rd(2'd1, "R4 gating reg untouched");

        // R8 / R10: awake pattern and restore
        wr(2'd1, 8'h0A);
        status("R8 awake enables follow 1010");
        wr(2'd1, 8'h02);
        status("R10 clear timer1 bit restores its clock");

        // R6: sleep without enable
        wr(2'd0, 8'h00);
        slp(1'b0, "R6 sleep ignored with enable clear");
        wr(2'd0, 8'h40);
        slp(1'b0, "R6 sleep ignored, select set, enable clear");

        // R5 / R7 / R8 / R9: every select code with a different gating pattern
        for (int s = 0; s < 4; s++) begin
            wr(2'd1, 8'(4'b0011 << s) & 8'h0F);
            wr(2'd0, 8'h20 | (s[1] ? 8'h40 : 8'h00) | (s[0] ? 8'h10 : 8'h00));
            slp(1'b0, (s == 0) ? "R5 R8 idle entry, enables follow gating" :
                      (s == 2) ? "R5 R9 standby entry, enables off" :
                                 "R5 R9 power-down entry, enables off");
            status("R5 mode held one cycle later");
            wk("R7 wake returns awake");
            rd(2'd0, "R7 sleep-enable still set after wake");
        end

        // R10 during idle
        wr(2'd1, 8'h0F);
        wr(2'd0, 8'h20);
        slp(1'b0, "R5 idle entry with all gated");
        wr(2'd1, 8'h0E);
        status("R10 clear usart bit in idle restores clock");
        wk("R7 wake from idle");

        // R11: select change while asleep
        wr(2'd0, 8'h30);
        slp(1'b0, "R11 enter power-down");
        wr(2'd0, 8'h20);
        status("R11 select write during sleep keeps power-down");
        tick();
        status("R11 still power-down");
        wk("R11 wake");

        // R12: wake with sleep pulse, and pulse while asleep
        wr(2'd0, 8'h60);
        slp(1'b1, "R12 wake in same cycle blocks entry");
        slp(1'b0, "R12 standby entry");
        wr(2'd0, 8'h20);
        slp(1'b0, "R12 sleep pulse while asleep ignored");
        wk("R12 wake after ignored pulse");

        tick();
        tick();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule